// File: doc/BRIEF.md
# External Trigger Clock Conditioner

This block lets a 16-bit up-counter run from an asynchronous external pin instead of the internal clock. The pin first passes through a two-flop synchronizer. A polarity control then decides whether high levels and rising edges are active, or low levels and falling edges. A small state machine finds active edges in the internal clock domain. A prescaler keeps one active edge out of every 1, 2, 4 or 8. Each edge that survives the prescaler becomes a single-cycle count-enable pulse.

External clocking can be selected in two ways. The first is a dedicated enable. The second is a slave-mode / trigger-select pair, both set to 7, which routes the same conditioned trigger to the counter. When both are set, the conditioned trigger is still the clock source.

One combination is illegal: the dedicated enable together with a trigger select of 7 and a slave mode other than 0 or 7. The block raises a flag for it and holds the counter. When no external mode is selected, the counter advances on every internal clock cycle. The prescaled edge rate must stay at or below a quarter of the internal clock rate.

The edge state machine has three states:
- `TRG_INIT`: the first cycle after reset. It loads the current level without reporting an edge. Its transitions are START_LOW and START_HIGH.
- `TRG_LOW`: the active level is absent. When the active level appears, transition RISE reports an edge and moves to `TRG_HIGH`.
- `TRG_HIGH`: the active level is present. When the level drops, transition FALL moves to `TRG_LOW` with no output.

The clock source decode has three values: `SRC_INT`, `SRC_EXT` and `SRC_BAD`.

Top module: `ext_trig_clk_cond`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count_q` becomes 0 and `trig_pulse` stays 0.
- R2: When no external mode is selected, `count_q` increments by one on every clock edge. This applies when `ext_mode2_en`=0 and the pair (`slave_mode`,`trig_sel`) is not (7,7).
- R3: With `trig_pol`=0, rising edges of `ext_trig_in` are active. With `trig_pol`=1, falling edges are active.
- R4: A change on `ext_trig_in` driven between clock edges is counted at the third rising clock edge after it. The count does not change at the first or second edge.
- R5: `psc_sel` selects how many active edges make one pulse: 0 → every edge, 1 → every 2nd, 2 → every 4th, 3 → every 8th.
- R6: A change of `psc_sel` clears the partial prescaler count. The next pulse then needs a full new group of edges.
- R7: With `ext_mode2_en`=1 and a legal configuration, `count_q` advances by one for each `trig_pulse` and is otherwise held. This includes a `trig_sel` other than 7 with any `slave_mode`.
- R8: With `slave_mode`=7 and `trig_sel`=7, the counter behaves exactly as under R7.
- R9: When both external selections are active at once, the counter still counts `trig_pulse`.
- R10: `cfg_illegal` is 1 exactly when `ext_mode2_en`=1, `trig_sel`=7 and `slave_mode` is neither 0 nor 7. While it is 1, `count_q` holds.
- R11: `count_q` wraps from 0xFFFF to 0x0000.
- R12: `trig_pulse` is high for one cycle per prescaled active edge and never high on two consecutive cycles. A level held steady produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| trig_pol | input | 1 | 0: rising edges active, 1: falling edges active |
| psc_sel | input | 2 | Prescaler code (divide by 1, 2, 4, 8) |
| ext_mode2_en | input | 1 | Dedicated external clock enable |
| slave_mode | input | 3 | Slave mode code; 7 with trig_sel 7 selects external clocking |
| trig_sel | input | 3 | Trigger select code; 7 routes the conditioned trigger |
| count_q | output | 16 | Counter value |
| trig_pulse | output | 1 | Conditioned, prescaled trigger pulse |
| cfg_illegal | output | 1 | Illegal configuration flag |

## Verification
The bench goes after the synchronizer latency. If a stage were dropped or added, the count would move one cycle early or late. It changes the prescaler code in the middle of a group of edges. A design that kept the stale partial count would then pulse too soon. It holds the input level steady and flips the polarity. A level-sensitive or wrongly inverted design would count continuously or count the wrong edge. It also walks the counter through the 0xFFFF wrap, the overlap of both external selections, and the illegal combination. A design with a wrong priority or illegal decode would count from the internal clock or keep counting when it should hold.

// File: rtl/etc_pkg.sv
package etc_pkg;
    typedef enum logic [1:0] {
        TRG_INIT = 2'd0,
        TRG_LOW  = 2'd1,
        TRG_HIGH = 2'd2
    } trg_state_e;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_EXT = 2'd1,
        SRC_BAD = 2'd2
    } clk_src_e;
endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/etc_edge_fsm.sv
module etc_edge_fsm
    import etc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic invert,
    output logic edge_out
);
    trg_state_e state_q, state_d;
    logic       lvl;

    assign lvl = sync_in ^ invert;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRG_INIT;
        else        state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d  = state_q;
        edge_out = 1'b0;
        unique case (state_q)
            TRG_INIT: state_d = lvl ? TRG_HIGH : TRG_LOW;   // START_HIGH / START_LOW
            TRG_LOW: begin
                if (lvl) begin                              // RISE
                    state_d  = TRG_HIGH;
                    edge_out = 1'b1;
                end
            end
            TRG_HIGH: if (!lvl) state_d = TRG_LOW;          // FALL
            default:  state_d = TRG_INIT;
        endcase
    end

    assert_edge_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        edge_out |=> !edge_out);
endmodule

// File: rtl/etc_prescaler.sv
module etc_prescaler #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] code,
    input  logic             edge_in,
    output logic             pulse_out
);
    localparam int PCNT_W = (1 << PSC_W) - 1;

    logic [PSC_W-1:0]  code_q;
    logic [PCNT_W-1:0] cnt_q;
    logic [PCNT_W-1:0] last;
    logic              same_code;

    assign last      = PCNT_W'((1 << code) - 1);
    assign same_code = (code == code_q);
    assign pulse_out = edge_in && same_code && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            cnt_q  <= '0;
        end else begin
            code_q <= code;
            if (!same_code)   cnt_q <= '0;
            else if (edge_in) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end
    end

    assert_psc_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> edge_in);
    assert_psc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code != code_q) |=> (cnt_q == '0));
endmodule

// File: rtl/ext_trig_clk_cond.sv
module ext_trig_clk_cond
    import etc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 2,
    parameter int MODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_trig_in,
    input  logic              trig_pol,
    input  logic [PSC_W-1:0]  psc_sel,
    input  logic              ext_mode2_en,
    input  logic [MODE_W-1:0] slave_mode,
    input  logic [MODE_W-1:0] trig_sel,
    output logic [CNT_W-1:0]  count_q,
    output logic              trig_pulse,
    output logic              cfg_illegal
);
    localparam logic [MODE_W-1:0] EXT_CODE = '1;

    logic     ext_sync;
    logic     edge_hit;
    logic     psc_pulse;
    logic     mode1_sel;
    clk_src_e src;
    logic     cnt_en;

    etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(ext_trig_in), .d_out(ext_sync)
    );

    etc_edge_fsm u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(ext_sync), .invert(trig_pol),
        .edge_out(edge_hit)
    );

    etc_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .code(psc_sel), .edge_in(edge_hit),
        .pulse_out(psc_pulse)
    );

    // clock source decode
    assign mode1_sel   = (slave_mode == EXT_CODE) && (trig_sel == EXT_CODE);
    assign cfg_illegal = ext_mode2_en && (trig_sel == EXT_CODE)
                         && (slave_mode != '0) && (slave_mode != EXT_CODE);

    always_comb begin
        if (cfg_illegal)                    src = SRC_BAD;
        else if (ext_mode2_en || mode1_sel) src = SRC_EXT;
        else                                src = SRC_INT;
    end

    always_comb begin
        unique case (src)
            SRC_INT: cnt_en = 1'b1;
            SRC_EXT: cnt_en = psc_pulse;
            SRC_BAD: cnt_en = 1'b0;
            default: cnt_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (cnt_en) count_q <= count_q + 1'b1;
    end

    assign trig_pulse = psc_pulse && rst_n;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0));
    assert_int_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode2_en && !mode1_sel) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));
    assert_ext_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode2_en && !cfg_illegal && !trig_pulse) |=> $stable(count_q));
    assert_hold_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal |=> $stable(count_q));
endmodule

// File: tb/tb_ext_trig_clk_cond.sv
`timescale 1ns/100ps
module tb_ext_trig_clk_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_trig_in = 1'b0;
    logic        trig_pol = 1'b0;
    logic [1:0]  psc_sel = 2'd0;
    logic        ext_mode2_en = 1'b0;
    logic [2:0]  slave_mode = 3'd0;
    logic [2:0]  trig_sel = 3'd0;
    logic [15:0] count_q;
    logic        trig_pulse;
    logic        cfg_illegal;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ext_trig_clk_cond dut (
        .clk(clk), .rst_n(rst_n), .ext_trig_in(ext_trig_in), .trig_pol(trig_pol),
        .psc_sel(psc_sel), .ext_mode2_en(ext_mode2_en), .slave_mode(slave_mode),
        .trig_sel(trig_sel), .count_q(count_q), .trig_pulse(trig_pulse),
        .cfg_illegal(cfg_illegal)
    );

    // behavioural reference model
    int m_hist[$];           // raw samples, newest last
    int m_level_known = 0;   // 0 until first level seen after reset
    int m_prev_active = 0;
    int m_group = 0;         // edges accumulated toward one pulse
    int m_code = 0;
    int m_count = 0;

    function automatic int synced();
        if (m_hist.size() < 2) return 0;
        return m_hist[m_hist.size()-2];
    endfunction

    function automatic int active_now();
        return synced() ^ int'(trig_pol);
    endfunction

    function automatic int edge_now();
        return (m_level_known != 0 && m_prev_active == 0 && active_now() == 1) ? 1 : 0;
    endfunction

    function automatic int exp_illegal();
        return (ext_mode2_en && trig_sel == 3'd7 && slave_mode != 3'd0
                && slave_mode != 3'd7) ? 1 : 0;
    endfunction

    function automatic int exp_pulse();
        if (!rst_n) return 0;
        return (edge_now() == 1 && int'(psc_sel) == m_code
                && m_group == (1 << m_code) - 1) ? 1 : 0;
    endfunction

    function automatic int exp_ext();
        return (ext_mode2_en || (slave_mode == 3'd7 && trig_sel == 3'd7)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist.delete();
            m_hist.push_back(0);
            m_hist.push_back(0);
            m_level_known = 0;
            m_prev_active = 0;
            m_group = 0;
            m_code = 0;
            m_count = 0;
        end else begin
            int e, p;
            e = edge_now();
            p = exp_pulse();
            if (exp_illegal() == 0) begin
                if (exp_ext() == 1) begin
                    if (p == 1) m_count = (m_count + 1) % 65536;
                end else m_count = (m_count + 1) % 65536;
            end
            if (int'(psc_sel) != m_code) begin
                m_group = 0;
            end else if (e == 1) begin
                m_group = (m_group == (1 << m_code) - 1) ? 0 : m_group + 1;
            end
            m_code = int'(psc_sel);
            m_prev_active = active_now();
            m_level_known = 1;
            m_hist.push_back(int'(ext_trig_in));
            if (m_hist.size() > 4) void'(m_hist.pop_front());
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        total++;
        if (count_q !== 16'(m_count) || trig_pulse !== 1'(exp_pulse())
            || cfg_illegal !== 1'(exp_illegal())) begin
            bad++;
            $display("FAIL %s count=%h/%h pulse=%b/%0d illegal=%b/%0d (actual/expected)",
                     cur_req, count_q, 16'(m_count), trig_pulse, exp_pulse(),
                     cfg_illegal, exp_illegal());
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5;
        end
    endtask

    task automatic toggle_run(input int edges, input int spacing);
        for (int i = 0; i < edges; i++) begin
            ext_trig_in = ~ext_trig_in;
            tick(spacing);
        end
    endtask

    task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s value=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] snap;
        // R1: reset state
        cur_req = "R1";
        tick(4);
        check_val("R1", count_q, 16'h0);
        rst_n = 1'b1;
        // R2: internal counting
        cur_req = "R2";
        tick(20);
        // R7 and R3: mode 2, rising edges
        cur_req = "R7";
        ext_mode2_en = 1'b1;
        toggle_run(20, 4);
        // R4: synchronizer latency
        cur_req = "R4";
        ext_trig_in = 1'b0;
        tick(6);
        snap = count_q;
        ext_trig_in = 1'b1;
        tick(2);
        check_val("R4", count_q, snap);
        tick(1);
        check_val("R4", count_q, snap + 16'd1);
        tick(4);
        // R3: falling edges active
        cur_req = "R3";
        trig_pol = 1'b1;
        toggle_run(20, 3);
        trig_pol = 1'b0;
        toggle_run(10, 5);
        // R5 / R6: each prescaler code, with mid-group changes
        cur_req = "R5";
        for (int c = 0; c < 4; c++) begin
            psc_sel = 2'(c);
            toggle_run(40, 3);
        end
        cur_req = "R6";
        psc_sel = 2'd3;
        toggle_run(7, 3);
        psc_sel = 2'd2;
        toggle_run(5, 4);
        psc_sel = 2'd1;
        toggle_run(3, 3);
        psc_sel = 2'd3;
        toggle_run(20, 3);
        psc_sel = 2'd0;
        // R12: steady level gives no pulses
        cur_req = "R12";
        tick(25);
        toggle_run(9, 4);
        // R8: mode 1 routing only
        cur_req = "R8";
        ext_mode2_en = 1'b0;
        slave_mode = 3'd7;
        trig_sel = 3'd7;
        toggle_run(20, 4);
        // R9: both selections active
        cur_req = "R9";
        ext_mode2_en = 1'b1;
        psc_sel = 2'd1;
        toggle_run(20, 3);
        // R10: illegal combination holds count
        cur_req = "R10";
        slave_mode = 3'd3;
        snap = count_q;
        toggle_run(16, 3);
        check_val("R10", count_q, snap);
        slave_mode = 3'd5;
        toggle_run(6, 3);
        // R7: mode 2 with another slave mode, trigger select not 7
        cur_req = "R7";
        slave_mode = 3'd4;
        trig_sel = 3'd2;
        psc_sel = 2'd0;
        toggle_run(20, 4);
        // R11: wrap through internal counting
        cur_req = "R11";
        ext_mode2_en = 1'b0;
        slave_mode = 3'd0;
        trig_sel = 3'd0;
        tick(65600);
        // R1: reset again mid-run
        cur_req = "R1";
        rst_n = 1'b0;
        tick(3);
        check_val("R1", count_q, 16'h0);
        rst_n = 1'b1;
        cur_req = "R2";
        tick(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule